// File: doc/BRIEF.md
# Serial Gain-Word Control Interface

This block is the control side of one programmable-gain channel. A host reaches it over a four-wire serial link made up of a serial clock, a data input, a data output and an active-low latch. The block keeps a 6-bit gain code for the channel. It presents that code, and the signed gain in dB it stands for, on parallel outputs that drive the analog gain stages. All serial inputs are sampled by the block's own system clock through synchronizer chains. Edges of the serial clock and latch are found inside the block, so the serial link may run at any rate well below the system clock.

A transaction opens when the latch goes low and closes when it returns high. The first serial bit picks the mode: 1 means read and 0 means write. The second bit is a don't-care. In a write, six gain bits follow, LSB first. They are moved into the active gain register only when the latch closes after exactly eight bits; any other length leaves the register untouched. A code above 41 is clamped to 41, and codes 0 to 41 map to -9 dB up to +32 dB in 1 dB steps. In a read, the stored code is shifted out LSB first, with each bit changed after a serial-clock falling edge.

The controller states are: ST_IDLE (latch high, serial clock ignored), ST_MODE (waiting for the mode bit), ST_SKIP (waiting for the don't-care bit), ST_WR_BITS (collecting gain bits), ST_WR_FULL (six bits held, waiting for the latch to close), ST_RD_BITS (shifting the stored code out) and ST_DISCARD (too many bits, or read finished; further edges are ignored). The transitions are as follows. Latch fall moves ST_IDLE to ST_MODE. A serial rise moves ST_MODE to ST_SKIP. A serial rise moves ST_SKIP to ST_WR_BITS or ST_RD_BITS, according to the mode bit. The sixth rise moves ST_WR_BITS to ST_WR_FULL. A further rise moves ST_WR_FULL to ST_DISCARD. The sixth rise moves ST_RD_BITS to ST_DISCARD. From any state other than ST_IDLE, a latch rise returns to ST_IDLE, and only the exit from ST_WR_FULL commits the word.

Top module: `gain_serial_ctrl`

## Requirements
- R1: After reset the gain code is 0, the gain in dB is -9, and the data output and its enable are both low.
- R2: Serial clock edges that occur while the latch is high have no effect on the gain code or on the data output.
- R3: The first bit of a transaction selects the mode: a value of 0 starts a write and a value of 1 starts a read.
- R4: The second bit of a transaction is ignored; either value gives the same result.
- R5: In a write, bits three to eight carry the gain code LSB first. The code becomes active only after the latch rises, and the gain code changes at no other time.
- R6: A write transaction with fewer or more than eight bits leaves the gain code unchanged.
- R7: A written code above 41 is stored as 41, so the gain code never exceeds 41.
- R8: The dB output always equals the gain code minus 9, as a 7-bit two's-complement value covering -9 to +32.
- R9: In a read, the data output presents the stored code LSB first. Bit n is valid before the rising serial edge of transaction bit n+3 and is updated after each falling serial edge. A read does not alter the gain code.
- R10: While no transaction is open, the data output and its enable are low. The enable is high for as long as a transaction is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data in is taken on its rising edge |
| ser_latch_n | input | 1 | Active-low transaction frame; its rising edge closes a transaction |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out, read data LSB first |
| ser_dout_en | output | 1 | High while a transaction is open, for an external output buffer |
| gain_code | output | 6 | Active gain code, 0 to 41 |
| gain_db | output | 7 | Active gain in dB, signed, gain_code minus 9 |

## Verification
The bench writes codes with both values of the don't-care bit. A design that decoded that bit would store the wrong code or fall into read mode. It sends seven-bit and nine-bit writes, which a design that counted loosely would commit. It writes 42 and 63 to check the clamp at the edge of the legal range. It reads back asymmetric codes such as 21 and 37, which show a reversed bit order or a shift that is one edge early or late. It also toggles the serial clock with the latch high, and a design that ignored the frame would take those bits as a write.

// File: rtl/gain_ser_pkg.sv
package gain_ser_pkg;

    localparam int GAIN_W = 6;
    localparam int STEPS  = 42;
    localparam int MIN_DB = -9;
    localparam int DB_W   = GAIN_W + 1;
    localparam int CNT_W  = $clog2(GAIN_W);

    localparam logic [GAIN_W-1:0] MAX_CODE = GAIN_W'(STEPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_SKIP,
        ST_WR_BITS,
        ST_WR_FULL,
        ST_RD_BITS,
        ST_DISCARD
    } ser_state_e;

    function automatic logic [GAIN_W-1:0] clamp_code(input logic [GAIN_W-1:0] c);
        return (c > MAX_CODE) ? MAX_CODE : c;
    endfunction

    function automatic logic signed [DB_W-1:0] code_to_db(input logic [GAIN_W-1:0] c);
        return signed'(DB_W'({1'b0, c}) + DB_W'(MIN_DB));
    endfunction

endpackage

// File: rtl/gain_ser_sync.sv
module gain_ser_sync #(
    parameter int              STAGES  = 2,
    parameter int              N       = 3,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[g]}};
                    prev  <= RST_VAL[g];
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[g]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign level[g] = chain[STAGES-1];
            assign rise[g]  = chain[STAGES-1] & ~prev;
            assign fall[g]  = ~chain[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/gain_ser_fsm.sv
module gain_ser_fsm
    import gain_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              latch_rise,
    input  logic              latch_fall,
    input  logic              sdi,
    input  logic [GAIN_W-1:0] rd_word,
    output logic              dout,
    output logic              dout_en,
    output logic              commit,
    output logic [GAIN_W-1:0] commit_word
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(GAIN_W - 1);

    ser_state_e        state, state_n;
    logic              rd_sel;
    logic [CNT_W-1:0]  bit_cnt;
    logic [GAIN_W-1:0] shreg;
    logic              dout_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic; a closing latch has priority over serial edges
    always_comb begin
        state_n = state;
        if (state != ST_IDLE && latch_rise) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (latch_fall) state_n = ST_MODE;
                ST_MODE:    if (sclk_rise)  state_n = ST_SKIP;
                ST_SKIP:    if (sclk_rise)  state_n = rd_sel ? ST_RD_BITS : ST_WR_BITS;
                ST_WR_BITS: if (sclk_rise && bit_cnt == LAST_BIT) state_n = ST_WR_FULL;
                ST_WR_FULL: if (sclk_rise)  state_n = ST_DISCARD;
                ST_RD_BITS: if (sclk_rise && bit_cnt == LAST_BIT) state_n = ST_DISCARD;
                ST_DISCARD: state_n = ST_DISCARD;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sel      <= 1'b0;
            bit_cnt     <= '0;
            shreg       <= '0;
            dout_q      <= 1'b0;
            commit      <= 1'b0;
            commit_word <= '0;
        end else begin
            commit <= 1'b0;
            if (latch_rise && state == ST_WR_FULL) begin
                commit      <= 1'b1;
                commit_word <= shreg;
            end
            unique case (state)
                ST_MODE: begin
                    if (sclk_rise) rd_sel <= sdi;
                end
                ST_SKIP: begin
                    if (sclk_rise) begin
                        bit_cnt <= '0;
                        shreg   <= rd_sel ? rd_word : '0;
                    end
                end
                ST_WR_BITS: begin
                    if (sclk_rise) begin
                        shreg   <= {sdi, shreg[GAIN_W-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RD_BITS: begin
                    if (sclk_fall) begin
                        dout_q <= shreg[0];
                        shreg  <= {1'b0, shreg[GAIN_W-1:1]};
                    end
                    if (sclk_rise) bit_cnt <= bit_cnt + 1'b1;
                end
                default: ;
            endcase
            if (state_n != ST_RD_BITS) dout_q <= 1'b0;
        end
    end

    assign dout    = dout_q;
    assign dout_en = (state != ST_IDLE);

    AST_IDLE_DOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !dout); // R10
    AST_COMMIT_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(latch_rise)); // R5
    AST_DOUT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dout |-> (state == ST_RD_BITS || $past(state) == ST_RD_BITS)); // R9

endmodule

// File: rtl/gain_ser_reg.sv
module gain_ser_reg
    import gain_ser_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [GAIN_W-1:0]        word,
    output logic [GAIN_W-1:0]        code,
    output logic signed [DB_W-1:0]   db
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            db   <= DB_W'(MIN_DB);
        end else if (commit) begin
            code <= clamp_code(word);
            db   <= code_to_db(clamp_code(word));
        end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        code <= MAX_CODE); // R7
    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(code)); // R5
    AST_DB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        db == signed'(DB_W'({1'b0, code}) + DB_W'(MIN_DB))); // R8

endmodule

// File: rtl/gain_serial_ctrl.sv
module gain_serial_ctrl
    import gain_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk,
    input  logic                    ser_latch_n,
    input  logic                    ser_din,
    output logic                    ser_dout,
    output logic                    ser_dout_en,
    output logic [GAIN_W-1:0]       gain_code,
    output logic signed [DB_W-1:0]  gain_db
);

    localparam int IDX_CLK = 0;
    localparam int IDX_LAT = 1;
    localparam int IDX_DIN = 2;

    logic [2:0]        s_lvl, s_rise, s_fall;
    logic              commit;
    logic [GAIN_W-1:0] commit_word;
    logic              unused_sync;

    gain_ser_sync #(
        .STAGES  (SYNC_STAGES),
        .N       (3),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_din, ser_latch_n, ser_clk}),
        .level    (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    assign unused_sync = &{1'b0, s_lvl[IDX_CLK], s_lvl[IDX_LAT],
                           s_rise[IDX_DIN], s_fall[IDX_DIN]};

    gain_ser_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (s_rise[IDX_CLK]),
        .sclk_fall   (s_fall[IDX_CLK]),
        .latch_rise  (s_rise[IDX_LAT]),
        .latch_fall  (s_fall[IDX_LAT]),
        .sdi         (s_lvl[IDX_DIN]),
        .rd_word     (gain_code),
        .dout        (ser_dout),
        .dout_en     (ser_dout_en),
        .commit      (commit),
        .commit_word (commit_word)
    );

    gain_ser_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .word   (commit_word),
        .code   (gain_code),
        .db     (gain_db)
    );

endmodule

// File: tb/tb_gain_serial_ctrl.sv
module tb_gain_serial_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    typedef struct {
        string tag;
        int    code;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_latch_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic        ser_dout_en;
    logic [5:0]  gain_code;
    logic signed [6:0] gain_db;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb_q[$];
    event smp_ev;

    gain_serial_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_latch_n (ser_latch_n),
        .ser_din     (ser_din),
        .ser_dout    (ser_dout),
        .ser_dout_en (ser_dout_en),
        .gain_code   (gain_code),
        .gain_db     (gain_db)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // frame bit k is shifted at slot k; bit0 = mode, bit1 = don't-care
    task automatic shift_frame(input logic [15:0] bits, input int n,
                               output logic [5:0] rd, output bit en_ok);
        rd = '0;
        en_ok = 1;
        ser_latch_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) begin
            ser_din = bits[k];
            wait_clk(HALF);
            if (k >= 2 && k < 8) rd[k-2] = ser_dout;
            if (!ser_dout_en) en_ok = 0;
            ser_clk = 1'b1;
            wait_clk(HALF);
            ser_clk = 1'b0;
        end
        wait_clk(HALF);
        ser_latch_n = 1'b1;
        ser_din = 1'b0;
        wait_clk(12);
    endtask

    function automatic int clamp(input int c);
        return (c > 41) ? 41 : c;
    endfunction

    task automatic push_exp(input string tag, input int code);
        exp_t e;
        e.tag = tag;
        e.code = code;
        sb_q.push_back(e);
        -> smp_ev;
        wait_clk(2);
    endtask

    // write of n bits; the stored value is expected only for n == 8
    task automatic wr(input string tag, input int code, input logic skip,
                      input int n, input int exp_code);
        logic [5:0] rd;
        bit en_ok;
        logic [15:0] f;
        f = {7'b0, 1'b1, code[5:0], skip, 1'b0};
        shift_frame(f, n, rd, en_ok);
        push_exp(tag, exp_code);
    endtask

    task automatic rd_chk(input string tag, input logic skip, input int exp_code);
        logic [5:0] rd;
        bit en_ok;
        shift_frame({14'b0, skip, 1'b1}, 8, rd, en_ok);
        chk({tag, " R9 read data"}, int'(rd), exp_code);
        chk({tag, " R10 enable during read"}, int'(en_ok), 1);
        chk({tag, " R10 dout low after close"}, int'(ser_dout), 0);
        chk({tag, " R10 enable low after close"}, int'(ser_dout_en), 0);
        push_exp({tag, " R9 code kept by read"}, exp_code);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            exp_t e;
            @(smp_ev);
            e = sb_q.pop_front();
            chk({e.tag, " code"}, int'(gain_code), e.code);
            chk({e.tag, " R8 db"}, int'(gain_db), e.code - 9);
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        // R1 reset state
        chk("R1 code at reset", int'(gain_code), 0);
        chk("R1 db at reset", int'(gain_db), -9);
        chk("R1 dout at reset", int'(ser_dout), 0);
        chk("R1 enable at reset", int'(ser_dout_en), 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 code after release", int'(gain_code), 0);

        wr("R3 R5 write 5", 5, 1'b0, 8, 5);
        wr("R4 write 20 skip=1", 20, 1'b1, 8, 20);
        rd_chk("R3 read 20", 1'b0, 20);
        wr("R5 write 21 asym", 21, 1'b0, 8, 21);
        rd_chk("R4 read 21 skip=1", 1'b1, 21);
        wr("R7 write 63", 63, 1'b0, 8, 41);
        rd_chk("R7 read clamped", 1'b0, 41);
        wr("R7 write 42", 42, 1'b1, 8, 41);
        wr("R8 write 0", 0, 1'b0, 8, 0);
        wr("R8 write 41", 41, 1'b0, 8, clamp(41));
        wr("R5 write 37", 37, 1'b0, 8, 37);
        rd_chk("R9 read 37", 1'b0, 37);
        wr("R6 short write", 12, 1'b0, 7, 37);
        wr("R6 long write", 12, 1'b0, 9, 37);
        wr("R6 header only", 12, 1'b0, 2, 37);

        // R2 serial edges with latch high
        for (int k = 0; k < 8; k++) begin
            ser_din = k[0];
            wait_clk(HALF);
            ser_clk = 1'b1;
            wait_clk(2);
            chk("R2 dout with latch high", int'(ser_dout), 0);
            wait_clk(HALF - 2);
            ser_clk = 1'b0;
        end
        wait_clk(12);
        push_exp("R2 edges ignored", 37);
        rd_chk("R2 read after ignored edges", 1'b0, 37);

        wr("R5 write 1", 1, 1'b1, 8, 1);
        rd_chk("R9 read 1", 1'b0, 1);

        wait_clk(10);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule